// File: doc/BRIEF.md
# Fetch Queue Pointer Controller

This block tracks where a 64-entry fetch target queue stands. The queue sits between a branch predictor and an instruction fetch unit. Four circular pointers mark progress through the queue. The enqueue pointer shows where the next predicted block lands. The fetch pointer shows the next block to be sent to the fetch unit. The writeback pointer shows the next block whose pre-decode result is expected. The commit pointer shows the oldest block not yet retired. The block also keeps one status bit per entry, set while that entry is occupied.

Ordinary traffic moves each pointer forward by one step. Three recovery sources pull pointers back, and each one touches a different set of them. A later predictor stage can replace a block it already sent, which rewinds enqueue and, when needed, fetch. A pre-decode mispredict rewinds enqueue and fetch. A backend mispredict rewinds enqueue, fetch and writeback. A rewound pointer lands one past the redirecting entry, so that entry stays in the queue. Commit only ever moves forward.

Top module: `ftq_ptr_ctrl`

## Requirements
- R1: After reset all four pointers are 0, `q_empty` is 1, `q_full` is 0, `pred_ready` is 1, `fetch_req_valid` is 0 and every bit of `ent_valid` is 0.
- R2: When `pred_valid` and `pred_ready` are both high and no recovery is active, the enqueue pointer advances by one and `ent_valid` at the old enqueue index becomes 1. `pred_ready` is low while the queue is full, and a block offered then leaves the enqueue pointer unchanged.
- R3: Each pointer is 7 bits wide: bit 6 is a wrap bit and bits 5:0 are the entry index. `q_empty` is set when the enqueue and commit pointers are equal. `q_full` is set when their indices match and their wrap bits differ. `ent_valid` is set for exactly the entries from commit up to, but not including, enqueue.
- R4: `fetch_req_valid` is high whenever the fetch pointer differs from the enqueue pointer. With `fetch_ready` also high and no recovery active, the fetch pointer advances by one. `fetch_ready` has no effect when there is nothing to fetch.
- R5: `pd_valid` advances the writeback pointer by one when the writeback pointer differs from the fetch pointer. Otherwise `pd_valid` is ignored, along with its mispredict flag.
- R6: `cmt_pulse` advances the commit pointer by one and clears `ent_valid` at the old commit index, but only when the commit pointer differs from the writeback pointer. Otherwise the pulse is ignored. Commit is never rewound.
- R7: Override input k (0 = second stage, 1 = third stage) with pointer p sets enqueue to p+1. The fetch pointer becomes p if it had gone beyond p, and otherwise stays where it is. Entries after p are marked invalid. When several override flags are set, the highest k wins.
- R8: An accepted pre-decode writeback with `pd_mispred` set advances writeback and sets both enqueue and fetch to `pd_ptr`+1.
- R9: A backend redirect sets enqueue, fetch and writeback to `be_ptr`+1 on the next cycle. A commit in the same cycle still takes effect.
- R10: Recovery priority is backend, then pre-decode mispredict, then override. In any cycle with a recovery, that cycle's plain enqueue and fetch advance are dropped.
- R11: In circular distance from commit, commit ≤ writeback ≤ fetch ≤ enqueue ≤ 64 always holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_valid | input | 1 | Predictor offers a new block |
| pred_ready | output | 1 | Queue can take a block |
| ovr_flag | input | 2 | Per-stage override request, bit k for stage k |
| ovr_ptr | input | 2x7 | Per-stage pointer of the block being replaced |
| fetch_ready | input | 1 | Fetch unit accepts a request |
| fetch_req_valid | output | 1 | A block is waiting to be fetched |
| pd_valid | input | 1 | Pre-decode writeback strobe |
| pd_mispred | input | 1 | Pre-decode found a misprediction |
| pd_ptr | input | 7 | Pointer of the mispredicting block |
| be_valid | input | 1 | Backend mispredict redirect |
| be_ptr | input | 7 | Pointer of the backend-redirecting block |
| cmt_pulse | input | 1 | Every instruction of the oldest entry has committed |
| enq_ptr | output | 7 | Enqueue pointer |
| fetch_ptr | output | 7 | Fetch pointer |
| wb_ptr | output | 7 | Writeback pointer |
| cmt_ptr | output | 7 | Commit pointer |
| q_full | output | 1 | All 64 entries occupied |
| q_empty | output | 1 | No entries occupied |
| ent_valid | output | 64 | Per-entry occupancy status |

## Verification
Several events can land in the same cycle, and the bench stacks them to test the priority order. In one vector, a backend redirect, a pre-decode mispredict and a commit pulse arrive together. In another, a pre-decode mispredict coincides with a stage override and a new prediction. The expected pointers must show the winning recovery alone, with the commit still applied. The bench also fills the queue to the wrap point and then drains it with fetch, writeback and commit all active in every cycle. The final state must be empty, with all pointers matching.

// File: rtl/ftq_ptr_pkg.sv
package ftq_ptr_pkg;

    typedef enum logic [1:0] {
        RC_NONE = 2'd0,
        RC_OVR  = 2'd1,
        RC_PD   = 2'd2,
        RC_BE   = 2'd3
    } recov_e;

endpackage

// File: rtl/ftq_ptr_recover.sv
module ftq_ptr_recover
    import ftq_ptr_pkg::*;
#(
    parameter int PTR_W = 7,
    parameter int N_OVR = 2
) (
    input  logic                        be_valid,
    input  logic [PTR_W-1:0]            be_ptr,
    input  logic                        pd_mis,
    input  logic [PTR_W-1:0]            pd_ptr,
    input  logic [N_OVR-1:0]            ovr_flag,
    input  logic [N_OVR-1:0][PTR_W-1:0] ovr_ptr,
    input  logic [PTR_W-1:0]            cur_fetch,
    input  logic [PTR_W-1:0]            cur_cmt,
    output recov_e                      kind,
    output logic [PTR_W-1:0]            rs_enq,
    output logic [PTR_W-1:0]            rs_fetch,
    output logic [PTR_W-1:0]            rs_wb
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic             ovr_hit;
    logic [PTR_W-1:0] ovr_sel;
    logic [PTR_W-1:0] dist_fetch;
    logic [PTR_W-1:0] dist_ovr;

    // later stage (higher index) wins
    always_comb begin
        ovr_hit = 1'b0;
        ovr_sel = '0;
        for (int k = 0; k < N_OVR; k++) begin
            if (ovr_flag[k]) begin
                ovr_hit = 1'b1;
                ovr_sel = ovr_ptr[k];
            end
        end
    end

    assign dist_fetch = cur_fetch - cur_cmt;
    assign dist_ovr   = ovr_sel - cur_cmt;

    always_comb begin
        kind     = RC_NONE;
        rs_enq   = cur_fetch;
        rs_fetch = cur_fetch;
        rs_wb    = '0;
        if (be_valid) begin
            kind     = RC_BE;
            rs_enq   = be_ptr + ONE;
            rs_fetch = be_ptr + ONE;
            rs_wb    = be_ptr + ONE;
        end else if (pd_mis) begin
            kind     = RC_PD;
            rs_enq   = pd_ptr + ONE;
            rs_fetch = pd_ptr + ONE;
        end else if (ovr_hit) begin
            kind     = RC_OVR;
            rs_enq   = ovr_sel + ONE;
            rs_fetch = (dist_fetch > dist_ovr) ? ovr_sel : cur_fetch;
        end
    end

endmodule

// File: rtl/ftq_entry_status.sv
module ftq_entry_status #(
    parameter int IDX_W = 6,
    parameter int PTR_W = IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic                  clr_en,
    input  logic [IDX_W-1:0]      clr_idx,
    input  logic                  trim_en,
    input  logic [IDX_W-1:0]      base_idx,
    input  logic [PTR_W-1:0]      live_cnt,
    output logic [(1<<IDX_W)-1:0] valid
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_d, valid_q;
    logic [IDX_W-1:0] off;

    always_comb begin
        valid_d = valid_q;
        off     = '0;
        if (trim_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                off = IDX_W'(i) - base_idx;
                if ({1'b0, off} >= live_cnt) valid_d[i] = 1'b0;
            end
        end
        if (clr_en) valid_d[clr_idx] = 1'b0;
        if (set_en) valid_d[set_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    assign valid = valid_q;

endmodule

// File: rtl/ftq_ptr_ctrl.sv
module ftq_ptr_ctrl
    import ftq_ptr_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int N_OVR = 2,
    localparam int PTR_W = IDX_W + 1,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pred_valid,
    output logic                        pred_ready,
    input  logic [N_OVR-1:0]            ovr_flag,
    input  logic [N_OVR-1:0][PTR_W-1:0] ovr_ptr,
    input  logic                        fetch_ready,
    output logic                        fetch_req_valid,
    input  logic                        pd_valid,
    input  logic                        pd_mispred,
    input  logic [PTR_W-1:0]            pd_ptr,
    input  logic                        be_valid,
    input  logic [PTR_W-1:0]            be_ptr,
    input  logic                        cmt_pulse,
    output logic [PTR_W-1:0]            enq_ptr,
    output logic [PTR_W-1:0]            fetch_ptr,
    output logic [PTR_W-1:0]            wb_ptr,
    output logic [PTR_W-1:0]            cmt_ptr,
    output logic                        q_full,
    output logic                        q_empty,
    output logic [DEPTH-1:0]            ent_valid
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] enq;
        logic [PTR_W-1:0] fetch;
        logic [PTR_W-1:0] wb;
        logic [PTR_W-1:0] cmt;
    } ptrs_t;

    ptrs_t            st_d, st_q;
    recov_e           kind;
    logic [PTR_W-1:0] rs_enq, rs_fetch, rs_wb;
    logic             full_w, empty_w, req_w;
    logic             enq_fire, fetch_fire, wb_fire, cmt_fire, pd_mis;
    logic [PTR_W-1:0] live_cnt;

    assign empty_w = (st_q.enq == st_q.cmt);
    assign full_w  = (st_q.enq[IDX_W-1:0] == st_q.cmt[IDX_W-1:0]) &&
                     (st_q.enq[IDX_W] != st_q.cmt[IDX_W]);
    assign req_w   = (st_q.fetch != st_q.enq);

    assign wb_fire  = pd_valid && (st_q.wb != st_q.fetch);
    assign pd_mis   = wb_fire && pd_mispred;
    assign cmt_fire = cmt_pulse && (st_q.cmt != st_q.wb);

    ftq_ptr_recover #(
        .PTR_W (PTR_W),
        .N_OVR (N_OVR)
    ) u_recover (
        .be_valid  (be_valid),
        .be_ptr    (be_ptr),
        .pd_mis    (pd_mis),
        .pd_ptr    (pd_ptr),
        .ovr_flag  (ovr_flag),
        .ovr_ptr   (ovr_ptr),
        .cur_fetch (st_q.fetch),
        .cur_cmt   (st_q.cmt),
        .kind      (kind),
        .rs_enq    (rs_enq),
        .rs_fetch  (rs_fetch),
        .rs_wb     (rs_wb)
    );

    assign enq_fire   = pred_valid && !full_w && (kind == RC_NONE);
    assign fetch_fire = fetch_ready && req_w && (kind == RC_NONE);

    always_comb begin
        st_d = st_q;
        if (enq_fire)                   st_d.enq   = st_q.enq + ONE;
        if (fetch_fire)                 st_d.fetch = st_q.fetch + ONE;
        if (wb_fire && kind != RC_BE)   st_d.wb    = st_q.wb + ONE;
        if (cmt_fire)                   st_d.cmt   = st_q.cmt + ONE;
        if (kind != RC_NONE) begin
            st_d.enq   = rs_enq;
            st_d.fetch = rs_fetch;
        end
        if (kind == RC_BE)              st_d.wb    = rs_wb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_cnt = st_d.enq - st_d.cmt;

    ftq_entry_status #(
        .IDX_W (IDX_W),
        .PTR_W (PTR_W)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (enq_fire),
        .set_idx  (st_q.enq[IDX_W-1:0]),
        .clr_en   (cmt_fire),
        .clr_idx  (st_q.cmt[IDX_W-1:0]),
        .trim_en  (kind != RC_NONE),
        .base_idx (st_d.cmt[IDX_W-1:0]),
        .live_cnt (live_cnt),
        .valid    (ent_valid)
    );

    assign pred_ready      = !full_w;
    assign fetch_req_valid = req_w;
    assign q_full          = full_w;
    assign q_empty         = empty_w;
    assign enq_ptr         = st_q.enq;
    assign fetch_ptr       = st_q.fetch;
    assign wb_ptr          = st_q.wb;
    assign cmt_ptr         = st_q.cmt;

endmodule

// File: rtl/ftq_ptr_ctrl_chk.sv
module ftq_ptr_ctrl_chk #(
    parameter int IDX_W = 6,
    parameter int N_OVR = 2,
    localparam int PTR_W = IDX_W + 1,
    localparam int DEPTH = 1 << IDX_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pd_valid,
    input logic                 be_valid,
    input logic [PTR_W-1:0]     be_ptr,
    input logic [N_OVR-1:0]     ovr_flag,
    input logic [PTR_W-1:0]     enq_ptr,
    input logic [PTR_W-1:0]     fetch_ptr,
    input logic [PTR_W-1:0]     wb_ptr,
    input logic [PTR_W-1:0]     cmt_ptr,
    input logic                 q_full,
    input logic                 q_empty,
    input logic                 fetch_req_valid,
    input logic [DEPTH-1:0]     ent_valid
);

    logic [PTR_W-1:0] d_wb, d_fetch, d_enq, be_nxt;

    assign d_wb    = wb_ptr - cmt_ptr;
    assign d_fetch = fetch_ptr - cmt_ptr;
    assign d_enq   = enq_ptr - cmt_ptr;
    assign be_nxt  = be_ptr + PTR_W'(1);

    AST_PTR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wb <= d_fetch) && (d_fetch <= d_enq) && (d_enq <= PTR_W'(DEPTH))); // R11

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !be_valid && !pd_valid && (ovr_flag == '0)) |=> (enq_ptr == $past(enq_ptr))); // R2

    AST_BE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |=> (wb_ptr == $past(be_nxt)) && (fetch_ptr == $past(be_nxt)) && (enq_ptr == $past(be_nxt))); // R9

    AST_CMT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cmt_ptr == $past(cmt_ptr)) || (cmt_ptr == $past(cmt_ptr) + PTR_W'(1)))); // R6

    AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> (ent_valid == '0)); // R3

    AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> (&ent_valid)); // R3

    AST_REQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_valid |-> !q_empty); // R4

endmodule

bind ftq_ptr_ctrl ftq_ptr_ctrl_chk #(
    .IDX_W (IDX_W),
    .N_OVR (N_OVR)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .pd_valid        (pd_valid),
    .be_valid        (be_valid),
    .be_ptr          (be_ptr),
    .ovr_flag        (ovr_flag),
    .enq_ptr         (enq_ptr),
    .fetch_ptr       (fetch_ptr),
    .wb_ptr          (wb_ptr),
    .cmt_ptr         (cmt_ptr),
    .q_full          (q_full),
    .q_empty         (q_empty),
    .fetch_req_valid (fetch_req_valid),
    .ent_valid       (ent_valid)
);

// File: tb/ftq_ptr_ctrl_bench.sv
module ftq_ptr_ctrl_bench;

    localparam int IDX_W = 6;
    localparam int N_OVR = 2;
    localparam int PTR_W = IDX_W + 1;
    localparam int DEPTH = 1 << IDX_W;
    localparam int NVEC  = 23;

    typedef struct packed {
        logic       pv, fr, pdv, pdm;
        logic [6:0] pdp;
        logic       bev;
        logic [6:0] bep;
        logic       cp;
        logic [1:0] of;
        logic [6:0] o2, o3, ee, ef, ew, ec;
        logic [3:0] rq;
    } vec_t;

    function automatic vec_t mk(int pv, int fr, int pdv, int pdm, int pdp, int bev, int bep,
                                int cp, int of, int o2, int o3,
                                int ee, int ef, int ew, int ec, int rq);
        vec_t v;
        v.pv = pv[0]; v.fr = fr[0]; v.pdv = pdv[0]; v.pdm = pdm[0];
        v.pdp = 7'(pdp); v.bev = bev[0]; v.bep = 7'(bep); v.cp = cp[0];
        v.of = 2'(of); v.o2 = 7'(o2); v.o3 = 7'(o3);
        v.ee = 7'(ee); v.ef = 7'(ef); v.ew = 7'(ew); v.ec = 7'(ec); v.rq = 4'(rq);
        return v;
    endfunction

    //                       pv fr pdv pdm pdp bev bep cp of o2 o3   enq fet wb cmt req
    localparam vec_t TBL [NVEC] = '{
        mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,  1, 0, 0, 0,  2),  // R2 enqueue
        mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,  2, 0, 0, 0,  2),
        mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,  3, 0, 0, 0,  2),
        mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0,  4, 1, 0, 0,  4),  // R4 fetch issue
        mk(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0,  4, 2, 1, 0,  5),  // R5 writeback
        mk(0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0,  4, 3, 1, 1,  6),  // R6 commit
        mk(0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0,  4, 3, 2, 1,  6),  // R6 commit ignored at wb
        mk(1, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0,  3, 2, 2, 1,  7),  // R7 stage override, fetch clamped
        mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0,  4, 3, 2, 1,  4),
        mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0,  5, 4, 2, 1,  2),
        mk(0, 0, 0, 0, 0, 0, 0, 0, 3, 4, 3,  4, 3, 2, 1,  7),  // R7 later stage wins
        mk(1, 0, 1, 1, 2, 0, 0, 0, 1, 3, 0,  3, 3, 3, 1, 10),  // R10 pd beats override
        mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,  4, 3, 3, 1,  2),
        mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0,  5, 4, 3, 1,  4),
        mk(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0,  6, 5, 4, 1,  5),
        mk(0, 0, 1, 1, 4, 1, 2, 1, 0, 0, 0,  3, 3, 3, 2, 10),  // R10 backend beats pd, commit kept
        mk(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0,  3, 3, 3, 2,  5),  // R5 R4 ignored when caught up
        mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0,  3, 3, 3, 3,  6),
        mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,  4, 3, 3, 3,  2),
        mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0,  5, 4, 3, 3,  4),
        mk(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0,  6, 5, 4, 3,  5),
        mk(1, 1, 1, 1, 4, 0, 0, 0, 0, 0, 0,  5, 5, 5, 3,  8),  // R8 pre-decode mispredict
        mk(0, 0, 0, 0, 0, 1, 3, 1, 0, 0, 0,  4, 4, 4, 4,  9)   // R9 backend redirect
    };

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        pred_valid = 1'b0;
    logic                        pred_ready;
    logic [N_OVR-1:0]            ovr_flag = '0;
    logic [N_OVR-1:0][PTR_W-1:0] ovr_ptr = '0;
    logic                        fetch_ready = 1'b0;
    logic                        fetch_req_valid;
    logic                        pd_valid = 1'b0;
    logic                        pd_mispred = 1'b0;
    logic [PTR_W-1:0]            pd_ptr = '0;
    logic                        be_valid = 1'b0;
    logic [PTR_W-1:0]            be_ptr = '0;
    logic                        cmt_pulse = 1'b0;
    logic [PTR_W-1:0]            enq_ptr, fetch_ptr, wb_ptr, cmt_ptr;
    logic                        q_full, q_empty;
    logic [DEPTH-1:0]            ent_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ftq_ptr_ctrl #(.IDX_W(IDX_W), .N_OVR(N_OVR)) u_ftq_ptr_ctrl (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_ready(pred_ready),
        .ovr_flag(ovr_flag), .ovr_ptr(ovr_ptr), .fetch_ready(fetch_ready),
        .fetch_req_valid(fetch_req_valid), .pd_valid(pd_valid), .pd_mispred(pd_mispred),
        .pd_ptr(pd_ptr), .be_valid(be_valid), .be_ptr(be_ptr), .cmt_pulse(cmt_pulse),
        .enq_ptr(enq_ptr), .fetch_ptr(fetch_ptr), .wb_ptr(wb_ptr), .cmt_ptr(cmt_ptr),
        .q_full(q_full), .q_empty(q_empty), .ent_valid(ent_valid)
    );

    function automatic logic [DEPTH-1:0] live_mask(logic [6:0] c, logic [6:0] e);
        logic [DEPTH-1:0] m = '0;
        logic [6:0] cnt = e - c;
        for (int i = 0; i < DEPTH; i++) begin
            logic [5:0] off = 6'(i) - c[5:0];
            m[i] = ({1'b0, off} < cnt);
        end
        return m;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        pred_valid = 1'b0; fetch_ready = 1'b0; pd_valid = 1'b0; pd_mispred = 1'b0;
        be_valid = 1'b0; cmt_pulse = 1'b0; ovr_flag = '0;
    endtask

    task automatic check_reset_state();
        check("R1 ptrs", {enq_ptr, fetch_ptr, wb_ptr, cmt_ptr}, '0);
        check("R1 flags", {q_empty, q_full, pred_ready, fetch_req_valid}, 128'b1010);
        check("R1 valid", ent_valid, '0);
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1;
        check_reset_state();
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_reset_state();

        for (int v = 0; v < NVEC; v++) begin
            pred_valid = TBL[v].pv; fetch_ready = TBL[v].fr;
            pd_valid = TBL[v].pdv; pd_mispred = TBL[v].pdm; pd_ptr = TBL[v].pdp;
            be_valid = TBL[v].bev; be_ptr = TBL[v].bep; cmt_pulse = TBL[v].cp;
            ovr_flag = TBL[v].of; ovr_ptr = {TBL[v].o3, TBL[v].o2};
            @(posedge clk); #1;
            check($sformatf("R%0d vec%0d ptrs", TBL[v].rq, v),
                  {enq_ptr, fetch_ptr, wb_ptr, cmt_ptr},
                  {TBL[v].ee, TBL[v].ef, TBL[v].ew, TBL[v].ec});
            check($sformatf("R3 vec%0d valid", v), ent_valid, live_mask(TBL[v].ec, TBL[v].ee));
        end
        idle();
        check("R3 empty after table", {q_empty, q_full}, 128'b10);

        // fill past capacity: R2 refusal and R3 full at wrap
        pred_valid = 1'b1;
        repeat (70) @(posedge clk);
        #1;
        idle();
        check("R2 enq stops at full", enq_ptr, 128'd68);
        check("R3 full flags", {q_full, q_empty, pred_ready}, 128'b100);
        check("R3 full valid", ent_valid, {DEPTH{1'b1}});
        check("R4 req while full", fetch_req_valid, 128'b1);

        // drain with all three consumers active each cycle
        fetch_ready = 1'b1; pd_valid = 1'b1; cmt_pulse = 1'b1;
        repeat (70) @(posedge clk);
        #1;
        idle();
        check("R6 drained ptrs", {enq_ptr, fetch_ptr, wb_ptr, cmt_ptr},
              {7'd68, 7'd68, 7'd68, 7'd68});
        check("R3 drained flags", {q_empty, q_full, fetch_req_valid}, 128'b100);
        check("R6 drained valid", ent_valid, '0);

        // reset in the middle of traffic
        pred_valid = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        idle();
        rst_n = 1'b0;
        #2;
        check_reset_state();
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule